// File: doc/BRIEF.md
# I2C Target Transmitter with Event Status Codes

This block is the target side of an I2C link for the case where the bus controller reads. It watches the bus and recognises its own 7-bit address when the direction bit asks for a read. It then shifts bytes supplied by a local host out onto SDA, one at a time. Each bus event that needs host attention ends in a numbered 8-bit status code and a raised interrupt flag. While that flag is up the block holds SCL low, so the controller waits until the host has dealt with the event.

The host side is a set of write strobes. One loads the byte to send. The other updates four control bits: acknowledge enable, general-call enable, start request, and an interrupt-clear bit that is written as 1. When the host clears the flag while loading a byte, the acknowledge-enable value in that same write decides whether the byte is the last one. Open-drain SCL and SDA appear as separate input pins and output-enable pins, where an enable of 1 pulls the line low. Both inputs pass through a synchronizer and a glitch filter before the bus conditions are decoded.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset the status reads 0xF8, the interrupt flag is 0, and neither SCL nor SDA is pulled low.
- R2: With acknowledge enable 1, an address byte of the own 7-bit address (MSB first) followed by a read bit of 1 is acknowledged: SDA is pulled low during the ninth clock. After that clock the status reads 0xA8 and the interrupt flag is 1.
- R3: If the arbitration-lost input is high while the own read address is matched, the status reads 0xB0 instead of 0xA8.
- R4: While the interrupt flag is 1, SCL is held low. A control write with the clear bit 1 drops the flag and releases SCL. When the block is addressed, that same write also starts sending the loaded data byte.
- R5: Data bits leave MSB first, and SDA output-enable changes only while the filtered SCL is low, except when a START or STOP is seen.
- R6: When the controller acknowledges a byte (SDA low on the ninth rising SCL edge), and that byte was loaded with acknowledge enable 1, the status reads 0xB8 and the block waits for the next byte.
- R7: When the controller does not acknowledge a byte, the status reads 0xC0. After the host clears the flag the block is not addressed and drives nothing until it is next addressed.
- R8: When the controller acknowledges a byte that was loaded with acknowledge enable 0 (the last byte), the status reads 0xC8 and the block becomes not addressed.
- R9: With acknowledge enable 0 the own address is not acknowledged and the flag stays 0. Setting the bit to 1 again restores recognition without a reset. The own address with a write bit (0), and any other address, are never acknowledged.
- R10: The general-call byte 0x00 is acknowledged only when general-call enable and acknowledge enable are both 1. It raises no flag and leaves the status at 0xF8.
- R11: A STOP or a START seen in any state sets the status to 0xF8, clears the flag and releases both lines. After a repeated START the block decodes a new address byte.
- R12: If the host clears the flag with start request 1 while leaving the addressed state after 0xC0 or 0xC8, the block emits a one-cycle `bus_start` pulse only after a STOP has freed the bus.
- R13: An SDA pulse shorter than the filter length while SCL is high is not taken as a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| host_data_we | input | 1 | Load strobe for the transmit byte |
| host_data | input | 8 | Transmit byte |
| host_ctrl_we | input | 1 | Control write strobe |
| host_ack_en | input | 1 | Acknowledge enable / not-last-byte marker |
| host_gc_en | input | 1 | General-call enable |
| host_start_req | input | 1 | Request a START once the bus is free |
| host_int_clr | input | 1 | Write 1 to clear the interrupt flag |
| arb_lost_i | input | 1 | Arbitration was lost as controller during the address phase |
| status | output | 8 | Event status code |
| int_flag | output | 1 | Interrupt flag |
| bus_start | output | 1 | One-cycle pulse asking the controller side to issue START |

## Verification
Every result reacts to a line edge after a fixed delay: two synchronizer stages, three filter samples, the condition register and the engine register. Status, flag and SDA drive therefore move about seven cycles after the edge that causes them. The bench controller holds each SCL phase for 20 cycles. It samples SDA in the middle of the high phase and reads status and flag only after a whole low phase has passed since the ninth falling edge. Host writes take effect at the next edge, and the bench checks their effect on the following falling clock. The start-request pulse is counted over a whole window, before and after the STOP, rather than looked for in one cycle.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
   localparam logic [7:0] CODE_NONE      = 8'hF8;
   localparam logic [7:0] CODE_SLA_R     = 8'hA8;
   localparam logic [7:0] CODE_ARB_SLA_R = 8'hB0;
   localparam logic [7:0] CODE_DATA_ACK  = 8'hB8;
   localparam logic [7:0] CODE_DATA_NACK = 8'hC0;
   localparam logic [7:0] CODE_LAST_ACK  = 8'hC8;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ADDR,
      S_AACK,
      S_HOLD,
      S_TX,
      S_ACKW,
      S_NAWAIT
   } eng_state_e;
endpackage

// File: rtl/i2cst_filter.sv
module i2cst_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic lvl_o
);
   logic [SYNC_STAGES-1:0] sq;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq <= '1;
      else        sq <= {sq[SYNC_STAGES-2:0], pin_i};
   end
   assign synced = sq[SYNC_STAGES-1];

   generate
      if (FILT_LEN == 1) begin : g_nofilt
         assign lvl_o = synced;
      end else begin : g_filt
         logic [FILT_LEN-1:0] hist;
         logic                lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist  <= '1;
               lvl_q <= 1'b1;
            end else begin
               hist <= {hist[FILT_LEN-2:0], synced};
               if (&hist)       lvl_q <= 1'b1;
               else if (~|hist) lvl_q <= 1'b0;
            end
         end
         assign lvl_o = lvl_q;

         // R13: the filtered level never flips while the sampled history is mixed
         p_glitch_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
            (!(&hist) && !(~|hist)) |=> $stable(lvl_q));
      end
   endgenerate
endmodule

// File: rtl/i2cst_cond.sv
module i2cst_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise  = scl_f & ~scl_q;
   assign scl_fall  = ~scl_f & scl_q;
   assign start_det = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2cst_engine.sv
module i2cst_engine
   import i2cst_pkg::*;
#(
   parameter logic [6:0] OWN_ADDR = 7'h5A
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_f,
   input  logic       sda_f,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic       data_we,
   input  logic [7:0] data_in,
   input  logic       ctrl_we,
   input  logic       ctrl_ack_en,
   input  logic       ctrl_gc_en,
   input  logic       ctrl_start_req,
   input  logic       ctrl_int_clr,
   input  logic       arb_lost_i,
   output logic [7:0] status,
   output logic       int_flag,
   output logic       scl_oe,
   output logic       sda_oe,
   output logic       bus_start
);
   localparam int BITS  = 8;
   localparam int CNT_W = $clog2(BITS + 1);

   eng_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [BITS-1:0]  sreg, data_reg;
   logic             ack_en, gc_en, last_q, gc_hit, arb_q, m_ack;
   logic             pend, busy;
   logic             clr, own_hit, gc_match;

   assign clr      = ctrl_we & ctrl_int_clr & int_flag;
   assign own_hit  = (sreg[7:1] == OWN_ADDR) & sreg[0] & ack_en;
   assign gc_match = (sreg == '0) & gc_en & ack_en;
   assign scl_oe   = int_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         cnt      <= '0;
         sreg     <= '0;
         data_reg <= '0;
         status   <= CODE_NONE;
         int_flag <= 1'b0;
         sda_oe   <= 1'b0;
         ack_en   <= 1'b0;
         gc_en    <= 1'b0;
         last_q   <= 1'b0;
         gc_hit   <= 1'b0;
         arb_q    <= 1'b0;
         m_ack    <= 1'b0;
         pend     <= 1'b0;
         busy     <= 1'b0;
         bus_start <= 1'b0;
      end else begin
         bus_start <= 1'b0;
         if (data_we) data_reg <= data_in;
         if (ctrl_we) begin
            ack_en <= ctrl_ack_en;
            gc_en  <= ctrl_gc_en;
         end
         if (start_det)     busy <= 1'b1;
         else if (stop_det) busy <= 1'b0;
         if (pend && !busy && !start_det) begin
            bus_start <= 1'b1;
            pend      <= 1'b0;
         end

         if (start_det || stop_det) begin
            state    <= start_det ? S_ADDR : S_IDLE;
            cnt      <= '0;
            status   <= CODE_NONE;
            int_flag <= 1'b0;
            sda_oe   <= 1'b0;
         end else begin
            unique case (state)
               S_IDLE: ;
               S_ADDR: begin
                  if (scl_rise) begin
                     sreg <= {sreg[BITS-2:0], sda_f};
                     cnt  <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CNT_W'(BITS)) begin
                     cnt <= '0;
                     if (own_hit || gc_match) begin
                        sda_oe <= 1'b1;
                        gc_hit <= gc_match;
                        arb_q  <= arb_lost_i;
                        state  <= S_AACK;
                     end else begin
                        state <= S_IDLE;
                     end
                  end
               end
               S_AACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     if (gc_hit) begin
                        state <= S_IDLE;
                     end else begin
                        status   <= arb_q ? CODE_ARB_SLA_R : CODE_SLA_R;
                        int_flag <= 1'b1;
                        state    <= S_HOLD;
                     end
                  end
               end
               S_HOLD: begin
                  if (clr) begin
                     int_flag <= 1'b0;
                     sreg     <= data_reg;
                     last_q   <= ~ctrl_ack_en;
                     sda_oe   <= ~data_reg[BITS-1];
                     cnt      <= '0;
                     state    <= S_TX;
                  end
               end
               S_TX: begin
                  if (scl_fall) begin
                     if (cnt == CNT_W'(BITS - 1)) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= S_ACKW;
                     end else begin
                        sreg   <= {sreg[BITS-2:0], 1'b0};
                        sda_oe <= ~sreg[BITS-2];
                        cnt    <= cnt + 1'b1;
                     end
                  end
               end
               S_ACKW: begin
                  if (scl_rise) begin
                     m_ack <= ~sda_f;
                  end else if (scl_fall) begin
                     int_flag <= 1'b1;
                     if (!m_ack) begin
                        status <= CODE_DATA_NACK;
                        state  <= S_NAWAIT;
                     end else if (last_q) begin
                        status <= CODE_LAST_ACK;
                        state  <= S_NAWAIT;
                     end else begin
                        status <= CODE_DATA_ACK;
                        state  <= S_HOLD;
                     end
                  end
               end
               S_NAWAIT: begin
                  if (clr) begin
                     int_flag <= 1'b0;
                     state    <= S_IDLE;
                     if (ctrl_start_req) pend <= 1'b1;
                  end
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end

   // R2, R3, R6, R7, R8: the flag only rises together with an event code
   p_flag_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_flag) |-> (status == CODE_SLA_R || status == CODE_ARB_SLA_R ||
                           status == CODE_DATA_ACK || status == CODE_DATA_NACK ||
                           status == CODE_LAST_ACK));

   // R4: the code stays put while the host has not yet cleared the flag
   p_code_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int_flag && !(ctrl_we && ctrl_int_clr) && !start_det && !stop_det) |=> $stable(status));

   // R5: SDA drive never moves while SCL stays high, bus conditions aside
   p_sda_low_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_f && $past(scl_f) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

   // R11: a STOP leaves the block idle with lines released
   p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop_det) |-> (status == CODE_NONE && !int_flag && !sda_oe));

   // R12: the start request only goes out on a free bus
   p_start_free_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |-> !busy);
endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx #(
   parameter logic [6:0] OWN_ADDR    = 7'h5A,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       scl_oe,
   output logic       sda_oe,
   input  logic       host_data_we,
   input  logic [7:0] host_data,
   input  logic       host_ctrl_we,
   input  logic       host_ack_en,
   input  logic       host_gc_en,
   input  logic       host_start_req,
   input  logic       host_int_clr,
   input  logic       arb_lost_i,
   output logic [7:0] status,
   output logic       int_flag,
   output logic       bus_start
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1 || FILT_LEN > 16) begin : g_bad_filt
         $error("FILT_LEN must lie in 1..16");
      end
   endgenerate

   logic scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;

   i2cst_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(scl_i), .lvl_o(scl_f));

   i2cst_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(sda_i), .lvl_o(sda_f));

   i2cst_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   i2cst_engine #(.OWN_ADDR(OWN_ADDR)) u_eng (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .data_we(host_data_we), .data_in(host_data),
      .ctrl_we(host_ctrl_we), .ctrl_ack_en(host_ack_en),
      .ctrl_gc_en(host_gc_en), .ctrl_start_req(host_start_req),
      .ctrl_int_clr(host_int_clr), .arb_lost_i(arb_lost_i),
      .status(status), .int_flag(int_flag), .scl_oe(scl_oe),
      .sda_oe(sda_oe), .bus_start(bus_start));
endmodule

// File: tb/sim_i2c_slave_tx.sv
`timescale 1ns/1ps
module sim_i2c_slave_tx;
   localparam logic [6:0] OWN = 7'h5A;
   localparam int H = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic scl_i, sda_i, scl_oe, sda_oe;
   logic host_data_we = 1'b0, host_ctrl_we = 1'b0;
   logic [7:0] host_data = '0;
   logic host_ack_en = 1'b0, host_gc_en = 1'b0, host_start_req = 1'b0, host_int_clr = 1'b0;
   logic arb_lost_i = 1'b0;
   logic [7:0] status;
   logic int_flag, bus_start;

   int total = 0, bad = 0, pulses = 0;
   bit done = 1'b0, glitch_en = 1'b0, gc_cur = 1'b0;

   always #2 clk = ~clk;

   assign scl_i = !(m_scl_low || scl_oe);
   assign sda_i = !(m_sda_low || sda_oe);

   i2c_slave_tx #(.OWN_ADDR(OWN)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_oe(scl_oe), .sda_oe(sda_oe),
      .host_data_we(host_data_we), .host_data(host_data),
      .host_ctrl_we(host_ctrl_we), .host_ack_en(host_ack_en),
      .host_gc_en(host_gc_en), .host_start_req(host_start_req),
      .host_int_clr(host_int_clr), .arb_lost_i(arb_lost_i),
      .status(status), .int_flag(int_flag), .bus_start(bus_start));

   always @(negedge clk) if (bus_start) pulses++;

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_status(input bit mack, input bit last);
      if (!mack)     return 8'hC0;
      else if (last) return 8'hC8;
      else           return 8'hB8;
   endfunction

   task automatic host_load(input logic [7:0] d);
      host_data = d; host_data_we = 1'b1;
      waitc(1);
      host_data_we = 1'b0;
   endtask

   task automatic host_ctrl(input bit ae, input bit gc, input bit sr, input bit clr);
      host_ack_en = ae; host_gc_en = gc; host_start_req = sr; host_int_clr = clr;
      host_ctrl_we = 1'b1;
      waitc(1);
      host_ctrl_we = 1'b0; host_int_clr = 1'b0;
      waitc(1);
   endtask

   task automatic m_bit(input bit b, output bit rd);
      m_sda_low = !b;
      waitc(H);
      m_scl_low = 1'b0;
      while (!scl_i) waitc(1);
      waitc(H/2);
      rd = sda_i;
      if (glitch_en && b) begin
         m_sda_low = 1'b1; waitc(1); m_sda_low = 1'b0;
      end
      waitc(H/2);
      m_scl_low = 1'b1;
      waitc(H);
   endtask

   task automatic m_start;
      m_sda_low = 1'b0; waitc(H);
      m_scl_low = 1'b0;
      while (!scl_i) waitc(1);
      waitc(H);
      m_sda_low = 1'b1; waitc(H);
      m_scl_low = 1'b1; waitc(H);
   endtask

   task automatic m_stop;
      m_sda_low = 1'b1; waitc(H);
      m_scl_low = 1'b0;
      while (!scl_i) waitc(1);
      waitc(H);
      m_sda_low = 1'b0; waitc(H);
   endtask

   task automatic m_addr(input logic [7:0] byt, output bit acked);
      bit rd;
      for (int i = 7; i >= 0; i--) m_bit(byt[i], rd);
      m_bit(1'b1, rd);
      acked = !rd;
   endtask

   task automatic m_read(input bit mack, output logic [7:0] v);
      bit rd;
      for (int i = 7; i >= 0; i--) begin
         m_bit(1'b1, rd);
         v[i] = rd;
      end
      m_bit(!mack, rd);
   endtask

   task automatic do_txn(input int n, input bit nack_last, input bit last_flag,
                         input bit arb, input bit glitch);
      bit acked, fin, ae, mack;
      logic [7:0] v, d;
      m_start;
      arb_lost_i = arb; glitch_en = glitch;
      m_addr({OWN, 1'b1}, acked);
      glitch_en = 1'b0; arb_lost_i = 1'b0;
      check(glitch ? "R13 glitch ignored, ack" : "R2 own read acked", acked, 1);
      check(arb ? "R3 arbitration-lost code" : "R2 own read code", status, arb ? 8'hB0 : 8'hA8);
      check("R2 flag raised", int_flag, 1);
      check("R4 SCL pulled", scl_oe, 1);
      m_scl_low = 1'b0; waitc(10);
      check("R4 SCL line stays low", scl_i, 0);
      m_scl_low = 1'b1; waitc(2);
      for (int k = 0; k < n; k++) begin
         d = 8'($urandom);
         host_load(d);
         fin  = (k == n - 1);
         ae   = !(fin && last_flag);
         mack = !(fin && nack_last);
         host_ctrl(ae, gc_cur, 1'b0, 1'b1);
         check("R4 flag cleared", int_flag, 0);
         check("R4 SCL released", scl_oe, 0);
         m_read(mack, v);
         check("R5 data byte MSB first", v, d);
         check(mack ? (ae ? "R6 ack code" : "R8 last ack code") : "R7 nack code",
               status, exp_status(mack, !ae));
         check("R6 flag after byte", int_flag, 1);
      end
      host_ctrl(1'b1, gc_cur, 1'b0, 1'b1);
      m_read(1'b0, v);
      check("R7 not addressed, no drive", v, 8'hFF);
      m_stop;
      check("R11 stop code", status, 8'hF8);
   endtask

   initial begin
      bit acked;
      logic [7:0] v;
      bit rd;
      void'($urandom(32'h5EED1234));
      waitc(5);
      rst_n = 1'b1;
      waitc(5);
      check("R1 reset code", status, 8'hF8);
      check("R1 reset flag", int_flag, 0);
      check("R1 reset SCL", scl_oe, 0);
      check("R1 reset SDA", sda_oe, 0);

      // R9: address ignored while acknowledge enable is 0
      m_start;
      m_addr({OWN, 1'b1}, acked);
      check("R9 disabled, no ack", acked, 0);
      check("R9 disabled, no flag", int_flag, 0);
      m_stop;
      host_ctrl(1'b1, 1'b0, 1'b0, 1'b0);

      // directed: ack then nack; last byte; arbitration lost; glitch
      do_txn(2, 1'b1, 1'b0, 1'b0, 1'b0);
      do_txn(1, 1'b0, 1'b1, 1'b0, 1'b0);
      do_txn(1, 1'b1, 1'b0, 1'b1, 1'b0);
      do_txn(1, 1'b1, 1'b0, 1'b0, 1'b1);

      // R9: other address and own address with write bit
      m_start;
      m_addr({OWN ^ 7'h01, 1'b1}, acked);
      check("R9 foreign address no ack", acked, 0);
      m_stop;
      m_start;
      m_addr({OWN, 1'b0}, acked);
      check("R9 own write no ack", acked, 0);
      check("R9 own write no flag", int_flag, 0);
      m_stop;

      // R10: general call
      m_start;
      m_addr(8'h00, acked);
      check("R10 general call off, no ack", acked, 0);
      m_stop;
      gc_cur = 1'b1;
      host_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
      m_start;
      m_addr(8'h00, acked);
      check("R10 general call acked", acked, 1);
      check("R10 general call no flag", int_flag, 0);
      check("R10 general call code", status, 8'hF8);
      m_stop;
      gc_cur = 1'b0;
      host_ctrl(1'b1, 1'b0, 1'b0, 1'b0);

      // R11: STOP inside a byte
      m_start;
      m_addr({OWN, 1'b1}, acked);
      host_load(8'hFF);
      host_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) m_bit(1'b1, rd);
      m_stop;
      check("R11 stop mid-byte code", status, 8'hF8);
      check("R11 stop mid-byte flag", int_flag, 0);
      check("R11 stop mid-byte SDA", sda_oe, 0);
      check("R11 stop mid-byte SCL", scl_oe, 0);

      // R11: repeated START inside a byte, then a new address
      m_start;
      m_addr({OWN, 1'b1}, acked);
      host_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) m_bit(1'b1, rd);
      m_start;
      check("R11 repeated start code", status, 8'hF8);
      check("R11 repeated start flag", int_flag, 0);
      m_addr({OWN, 1'b1}, acked);
      check("R11 readdressed ack", acked, 1);
      check("R11 readdressed code", status, 8'hA8);
      host_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
      m_read(1'b0, v);
      check("R7 nack after restart", status, 8'hC0);
      host_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
      m_stop;

      // R12: start request waits for a free bus
      m_start;
      m_addr({OWN, 1'b1}, acked);
      host_load(8'h3C);
      host_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
      m_read(1'b0, v);
      check("R7 nack code before request", status, 8'hC0);
      pulses = 0;
      host_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
      waitc(30);
      check("R12 no start while busy", pulses, 0);
      m_stop;
      waitc(10);
      check("R12 one start after STOP", pulses, 1);
      host_ctrl(1'b1, 1'b0, 1'b0, 1'b0);

      // random transactions
      for (int t = 0; t < 12; t++) begin
         int n;
         bit nk, lf;
         n  = 1 + int'($urandom_range(2));
         nk = 1'($urandom);
         lf = 1'($urandom);
         if (!nk && !lf) nk = 1'b1;
         do_txn(n, nk, lf, 1'($urandom), 1'b0);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(negedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule